// File: doc/BRIEF.md
# Mode-Register Command Timing Guard

This block sits in the command path between a DRAM controller's scheduler and the device command bus. It looks at each requested command in the cycle it is presented and decides at once whether it may go out. A mode-register write (standard or extended) is let through only when every bank is precharged and the precharge recovery time has run out. After a mode-register write the bus is quiet for a set number of cycles. READ commands are held off until the delay-locked loop has been running for the full lock window.

The guard keeps three pieces of state. It tracks which banks are open from the ACTIVE, PRECHARGE and precharge-all commands it grants. It counts the cycles since the last granted precharge and since the last granted mode write. It runs a lock counter that restarts whenever the DLL is switched on, either by a mode write that enables it or by an exit from self refresh. A command that breaks a rule is refused, and a sticky error flag records the refusal until reset.

Top module: `mrs_cmd_guard`

## Requirements
- R1: After reset `err_o` is 0, all banks count as precharged, both recovery windows count as expired, and the DLL counts as off, so READ (code 2) is refused until the DLL has been enabled.
- R2: A mode write (code 6) is refused while any bank is open. ACTIVE (code 1) opens bank `bank_i`, PRECHARGE (code 4) closes bank `bank_i`, and precharge-all (code 5) closes all four banks.
- R3: If a precharge or precharge-all is granted in cycle t, a mode write is refused in cycles before t+TRP and allowed from cycle t+TRP.
- R4: If a mode write is granted in cycle t, every command other than NOP (code 0) is refused in cycles before t+TMRD. NOP is always granted.
- R5: If a mode write with `dll_set_i`=1 and `dll_on_i`=1 is granted in cycle t, READ is refused before cycle t+LOCK_CYC and granted from t+LOCK_CYC onward. A mode write with `dll_set_i`=0 leaves the DLL state unchanged.
- R6: A granted mode write with `dll_set_i`=1 and `dll_on_i`=0 disables the DLL. READ is then refused until a later enable has completed its own LOCK_CYC window.
- R7: Self-refresh exit (code 7) enables the DLL and restarts the lock window: if granted in cycle t, READ is refused before t+LOCK_CYC and granted from then on.
- R8: A refused command changes no tracked state and sets `err_o`, which stays 1 until reset.
- R9: `grant_o` is combinational: it is 1 in the same cycle that `cmd_valid_i` is 1 and the command obeys every rule, and it is 0 whenever `cmd_valid_i` is 0.
- R10: WRITE (code 3), ACTIVE, PRECHARGE and precharge-all are subject only to the R4 window and are granted with the DLL off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is requested this cycle |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 precharge-all, 6 mode write, 7 self-refresh exit |
| bank_i | input | 2 | Bank addressed by ACTIVE or PRECHARGE |
| dll_set_i | input | 1 | Mode write carries a DLL control field |
| dll_on_i | input | 1 | DLL control value: 1 enable, 0 disable |
| grant_o | output | 1 | Command may be issued this cycle |
| err_o | output | 1 | Sticky flag: a refused command was requested |

## Verification
The bench builds the guard with TRP=3, TMRD=2 and the full 200-cycle lock window. These values are small enough that every gap from zero to just past each recovery window can be swept, and the whole lock window can be probed with a READ every cycle. Because refused READs change no state, each probe marks exactly where the refusal ends. Each sweep restarts from reset, so the sticky error flag can be checked both for sequences with no violation and for sequences with one.

// File: rtl/mrs_cmd_guard_pkg.sv
package mrs_cmd_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_PREA  = 3'd5,
    CMD_MODE  = 3'd6,
    CMD_SREX  = 3'd7
  } cmd_e;
endpackage

// File: rtl/mrs_elapsed_cnt.sv
// Counts cycles since the last start pulse, saturating at MAX_CYC.
// A value of 0 means idle (never started or stopped); it does not advance.
module mrs_elapsed_cnt #(
  parameter int unsigned MAX_CYC   = 3,
  parameter bit          RST_SATUR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] MAX_V = CW'(MAX_CYC);
  localparam logic [CW-1:0] RST_V = RST_SATUR ? MAX_V : '0;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= RST_V;
    else if (stop_i)                      cnt_q <= '0;
    else if (start_i)                     cnt_q <= CW'(1);
    else if (cnt_q != '0 && cnt_q < MAX_V) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q >= MAX_V);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_V);

  p_start_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && MAX_CYC > 1) |=> !done_o);
endmodule

// File: rtl/mrs_bank_track.sv
module mrs_bank_track #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         act_i,
  input  logic                         pre_i,
  input  logic                         pre_all_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  output logic                         all_closed_o
);
  logic [NUM_BANKS-1:0] open_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    open_q[b] <= 1'b0;
      else if (pre_all_i || (pre_i && bank_i == b))   open_q[b] <= 1'b0;
      else if (act_i && bank_i == b)                  open_q[b] <= 1'b1;
    end
  end

  assign all_closed_o = (open_q == '0);

  p_prea_closes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_i |=> all_closed_o);
endmodule

// File: rtl/mrs_cmd_guard.sv
module mrs_cmd_guard
  import mrs_cmd_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned TRP       = 3,
  parameter int unsigned TMRD      = 2,
  parameter int unsigned LOCK_CYC  = 200
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         dll_set_i,
  input  logic                         dll_on_i,
  output logic                         grant_o,
  output logic                         err_o
);
  cmd_e cmd;
  logic all_closed, pre_done, mrd_done, lock_done;
  logic legal;
  logic g_act, g_pre, g_prea, g_mode, g_srex;
  logic err_q;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    legal = 1'b1;
    if (cmd != CMD_NOP) begin
      legal = mrd_done;
      case (cmd)
        CMD_MODE: legal = mrd_done && all_closed && pre_done;
        CMD_READ: legal = mrd_done && lock_done;
        default:  ;
      endcase
    end
  end

  assign grant_o = cmd_valid_i && legal;

  assign g_act  = grant_o && cmd == CMD_ACT;
  assign g_pre  = grant_o && cmd == CMD_PRE;
  assign g_prea = grant_o && cmd == CMD_PREA;
  assign g_mode = grant_o && cmd == CMD_MODE;
  assign g_srex = grant_o && cmd == CMD_SREX;

  mrs_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk_i, .rst_ni,
    .act_i(g_act), .pre_i(g_pre), .pre_all_i(g_prea), .bank_i,
    .all_closed_o(all_closed)
  );

  mrs_elapsed_cnt #(.MAX_CYC(TRP), .RST_SATUR(1'b1)) u_trp (
    .clk_i, .rst_ni,
    .start_i(g_pre || g_prea), .stop_i(1'b0), .done_o(pre_done)
  );

  mrs_elapsed_cnt #(.MAX_CYC(TMRD), .RST_SATUR(1'b1)) u_tmrd (
    .clk_i, .rst_ni,
    .start_i(g_mode), .stop_i(1'b0), .done_o(mrd_done)
  );

  // Lock counter: idle (0) while DLL is off; restarts on every enable.
  mrs_elapsed_cnt #(.MAX_CYC(LOCK_CYC), .RST_SATUR(1'b0)) u_lock (
    .clk_i, .rst_ni,
    .start_i(g_srex || (g_mode && dll_set_i && dll_on_i)),
    .stop_i(g_mode && dll_set_i && !dll_on_i),
    .done_o(lock_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_q <= 1'b0;
    else if (cmd_valid_i && !legal) err_q <= 1'b1;
  end
  assign err_o = err_q;

  p_mode_closed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g_mode |-> (all_closed && pre_done));

  p_mrd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_mode && TMRD >= 2) |=> !(grant_o && cmd != CMD_NOP));

  p_read_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cmd == CMD_READ) |-> lock_done);

  p_dll_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_mode && dll_set_i && !dll_on_i) |=> !lock_done);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_idle_no_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> !grant_o);
endmodule

// File: tb/mrs_cmd_guard_tb.sv
`timescale 1ns/1ps
module mrs_cmd_guard_tb;
  localparam int TRP = 3, TMRD = 2, LOCK = 200;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, MODE = 6, SREX = 7;

  logic clk = 0, rst_n = 0;
  logic valid = 0, dset = 0, don = 0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 0;
  logic grant, err;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mrs_cmd_guard #(.NUM_BANKS(4), .TRP(TRP), .TMRD(TMRD), .LOCK_CYC(LOCK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .bank_i(bank),
    .dll_set_i(dset), .dll_on_i(don), .grant_o(grant), .err_o(err)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic s, input logic o,
                      input logic exp, input string tag);
    @(negedge clk);
    valid = 1; cmd = c; bank = b; dset = s; don = o;
    #1 check(grant, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid = 0; cmd = NOP; dset = 0; don = 0;
      #1 check(grant, 1'b0, "R9 idle");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; valid = 0; cmd = NOP; dset = 0; don = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    // R1 reset state and R10 commands with DLL off
    do_reset();
    #1 check(err, 1'b0, "R1 err after reset");
    step(WR, 0, 0, 0, 1, "R10 write");
    step(ACT, 2, 0, 0, 1, "R10 act");
    step(PRE, 2, 0, 0, 1, "R10 pre");
    step(PREA, 0, 0, 0, 1, "R10 prea");
    idle(1);
    check(err, 1'b0, "R8 no err without violation");
    step(RD, 0, 0, 0, 0, "R1 read with dll off");
    idle(1);
    check(err, 1'b1, "R8 err set");
    idle(5);
    check(err, 1'b1, "R8 err sticky");

    // R1 mode write allowed right after reset; R9 NOP granted in window
    do_reset();
    step(MODE, 0, 0, 0, 1, "R1 mode after reset");
    step(NOP, 0, 0, 0, 1, "R4 nop in window");

    // R2 per-bank open state
    for (int b = 0; b < 4; b++) begin
      do_reset();
      step(ACT, 2'(b), 0, 0, 1, "R2 act");
      idle(4);
      step(MODE, 0, 0, 0, 0, "R2 mode with bank open");
      idle(3);
      step(PRE, 2'(3 - b), 0, 0, 1, "R2 pre other bank");
      idle(TRP);
      step(MODE, 0, 0, 0, (b == 3 - b) ? 1'b1 : 1'b0, "R2 mode after other pre");
      idle(3);
      step(PRE, 2'(b), 0, 0, 1, "R2 pre own bank");
      idle(TRP - 1);
      step(MODE, 0, 0, 0, 1, "R2 mode all closed");
    end
    do_reset();
    step(ACT, 0, 0, 0, 1, "R2 act0");
    step(ACT, 3, 0, 0, 1, "R2 act3");
    step(PRE, 0, 0, 0, 1, "R2 pre0");
    idle(TRP);
    step(MODE, 0, 0, 0, 0, "R2 mode bank3 open");
    idle(3);
    step(PREA, 0, 0, 0, 1, "R2 prea");
    idle(TRP - 1);
    step(MODE, 0, 0, 0, 1, "R2 mode after prea");

    // R3 sweep of precharge-to-mode gap
    for (int d = 0; d <= TRP + 1; d++) begin
      do_reset();
      step((d % 2) ? PRE : PREA, 1, 0, 0, 1, "R3 precharge");
      idle(d);
      step(MODE, 0, 0, 0, (d + 1 >= TRP) ? 1'b1 : 1'b0, "R3 tRP gap");
    end

    // R4 sweep of mode-to-command gap
    for (int d = 0; d <= TMRD + 1; d++) begin
      do_reset();
      step(MODE, 0, 0, 0, 1, "R4 mode");
      idle(d);
      step(WR, 0, 0, 0, (d + 1 >= TMRD) ? 1'b1 : 1'b0, "R4 tMRD gap");
    end

    // R8 refused ACT leaves banks closed
    do_reset();
    step(MODE, 0, 0, 0, 1, "R8 mode");
    step(ACT, 1, 0, 0, 0, "R8 act refused");
    idle(3);
    step(MODE, 0, 0, 0, 1, "R8 banks still closed");
    idle(1);
    check(err, 1'b1, "R8 err after refused act");

    // R5 lock window after enable
    do_reset();
    step(MODE, 0, 1, 1, 1, "R5 dll enable");
    for (int k = 1; k <= LOCK + 2; k++)
      step(RD, 0, 0, 0, (k >= LOCK) ? 1'b1 : 1'b0, "R5 read vs lock");
    step(MODE, 0, 0, 1, 1, "R5 mode no dll field");
    idle(TMRD);
    step(RD, 0, 0, 0, 1, "R5 dll kept");

    // R6 disable then re-enable
    idle(TMRD);
    step(MODE, 0, 1, 0, 1, "R6 dll disable");
    idle(2);
    for (int k = 0; k < LOCK + 20; k++)
      step(RD, 0, 0, 0, 0, "R6 read while off");
    idle(TMRD);
    step(MODE, 0, 1, 1, 1, "R6 dll re-enable");
    for (int k = 1; k <= LOCK + 1; k++)
      step(RD, 0, 0, 0, (k >= LOCK) ? 1'b1 : 1'b0, "R6 read after re-enable");

    // R7 self-refresh exit restarts window
    step(SREX, 0, 0, 0, 1, "R7 srex");
    for (int k = 1; k <= LOCK + 1; k++)
      step(RD, 0, 0, 0, (k >= LOCK) ? 1'b1 : 1'b0, "R7 read after srex");
    do_reset();
    step(SREX, 0, 0, 0, 1, "R7 srex from off");
    idle(LOCK - 2);
    step(RD, 0, 0, 0, 0, "R7 read one early");
    step(RD, 0, 0, 0, 1, "R7 read at window");

    idle(1);
    summary();
  end
endmodule